// File: doc/BRIEF.md
# UART Host Register Bank with FIFO Control

This block is the processor-facing register bank of a 16550-compatible UART. A 3-bit address, a write strobe and a read strobe select one byte-wide register. Bit 7 of the line control byte switches addresses 0 and 1 over to the two halves of the baud divisor. Address 2 has a different meaning for each direction. A read returns the interrupt identification byte, and a write loads the FIFO control settings, which cannot be read back. The transmit and receive data paths, line status, modem status and interrupt identity all come from neighbouring blocks as plain ports. This block only routes them.

The FIFO control write sets several outputs. The enable bit drives both queues. Two bits request a flush of the receive queue or the transmit queue, and each request produces a one-cycle pulse. One bit selects the DMA signalling mode, and a 2-bit field picks the receive trigger threshold. Writes that leave the enable bit clear update nothing except the enable bit. Any change of the enable bit flushes both queues.

Top module: `uart_hostregs`

## Requirements
- R1: After reset, fifo_en, dma_mode, rx_clr, tx_clr and divisor_out are 0, rx_trig is 1, and the line control, interrupt enable, modem control and scratch bytes read as 0.
- R2: At address 0 with line control bit 7 = 0, a write pulses tx_wr_pulse in the same cycle with tx_data_out = wdata, and a read pulses rx_rd_pulse and returns rx_data_in. With bit 7 = 1, address 0 reads and writes the low divisor byte, and neither pulse fires.
- R3: At address 1 with line control bit 7 = 0, the interrupt enable byte is accessed. Only its bits 3:0 are stored, and bits 7:4 read as 0. With bit 7 = 1, address 1 accesses the high divisor byte. divisor_out = {high, low} changes only on divisor writes.
- R4: A read at address 2 returns {fifo_en, fifo_en, 2'b00, iid_in}. The FIFO control settings never appear in rdata.
- R5: Address 3 is line control (8 bits, read/write). Address 4 is modem control (bits 5:0 stored, bits 7:6 read as 0). Address 5 returns lsr_in and address 6 returns msr_in, and writes to these two addresses change nothing. Address 7 is a free 8-bit scratch byte.
- R6: A write to address 2 sets fifo_en to wdata bit 0 from the next clock edge.
- R7: A write to address 2 with bit 0 = 0 leaves the DMA select bit and the trigger code unchanged, and its bits 1 and 2 cause no flush pulse.
- R8: A write to address 2 whose bit 0 differs from the current fifo_en raises both rx_clr and tx_clr in the cycle after the write.
- R9: With bit 0 = 1, writing bit 1 = 1 raises rx_clr, and writing bit 2 = 1 raises tx_clr, in the cycle after the write. Each pulse lasts exactly one cycle unless it is written again.
- R10: dma_mode equals the stored bit 3 of the last write with bit 0 = 1, and it is forced to 0 while fifo_en is 0.
- R11: rx_trig gives the receive threshold as a count: trigger code (wdata bits 7:6) 00, 01, 10, 11 map to 1, 4, 8, 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_data_in | input | 8 | Head byte of the receive queue |
| iid_in | input | 4 | Interrupt identity from the priority logic |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| tx_wr_pulse | output | 1 | Push strobe into the transmit queue |
| tx_data_out | output | 8 | Byte pushed into the transmit queue |
| rx_rd_pulse | output | 1 | Pop strobe for the receive queue |
| ier_out | output | 4 | Interrupt enable bits |
| lcr_out | output | 8 | Line control byte |
| mcr_out | output | 6 | Modem control bits |
| divisor_out | output | 16 | Baud divisor |
| fifo_en | output | 1 | Queues enabled |
| rx_clr | output | 1 | Receive queue flush pulse |
| tx_clr | output | 1 | Transmit queue flush pulse |
| dma_mode | output | 1 | DMA signalling mode 1 selected |
| rx_trig | output | 4 | Receive trigger threshold in bytes |

## Verification
Two flush causes can fall on the same clock edge. One is a change of the enable bit, and the other is an explicit flush bit in the same control write. The bench provokes this by writing a byte that sets the enable bit while it is clear, with one or both flush bits also set. It also issues a write that clears the enable bit while carrying flush bits. Each case is judged by sampling rx_clr and tx_clr exactly one edge after the write, where both must be high once with no double-length pulse, and again on the following edge, where both must have dropped.

// File: rtl/uart_hostregs_pkg.sv
package uart_hostregs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int IID_W  = 4;
  localparam int TRIG_W = 4;
  localparam int NREG   = 6;

  // storage slots of the byte register file
  localparam int SLOT_DLL = 0;
  localparam int SLOT_DLM = 1;
  localparam int SLOT_IER = 2;
  localparam int SLOT_LCR = 3;
  localparam int SLOT_MCR = 4;
  localparam int SLOT_SCR = 5;

  localparam int DLAB_BIT = 7;

  typedef enum logic [3:0] {
    RSEL_RBR, RSEL_DLL, RSEL_IER, RSEL_DLM, RSEL_IIR,
    RSEL_LCR, RSEL_MCR, RSEL_LSR, RSEL_MSR, RSEL_SCR
  } rsel_e;

  typedef struct packed {
    logic thr_wr;
    logic rbr_rd;
    logic fcr_wr;
  } strobes_t;

  // bits kept by each storage slot
  function automatic logic [DATA_W-1:0] slot_mask(input int slot);
    case (slot)
      SLOT_IER: slot_mask = 8'h0F;
      SLOT_MCR: slot_mask = 8'h3F;
      default:  slot_mask = 8'hFF;
    endcase
  endfunction

  // receive threshold code to byte count
  function automatic logic [TRIG_W-1:0] trig_count(input logic [1:0] code);
    case (code)
      2'd0:    trig_count = 4'd1;
      2'd1:    trig_count = 4'd4;
      2'd2:    trig_count = 4'd8;
      default: trig_count = 4'd14;
    endcase
  endfunction

  // interrupt identification byte as seen by the host
  function automatic logic [DATA_W-1:0] iir_byte(input logic en,
                                                 input logic [IID_W-1:0] iid);
    iir_byte = {en, en, 2'b00, iid};
  endfunction
endpackage

// File: rtl/uart_hostregs_decode.sv
module uart_hostregs_decode
  import uart_hostregs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              dlab,
  output strobes_t          stb,
  output logic [NREG-1:0]   slot_we,
  output rsel_e             rsel
);
  always_comb begin
    stb     = '0;
    slot_we = '0;
    rsel    = RSEL_SCR;
    case (addr)
      3'd0: begin
        if (dlab) begin
          slot_we[SLOT_DLL] = wr_en;
          rsel = RSEL_DLL;
        end else begin
          stb.thr_wr = wr_en;
          stb.rbr_rd = rd_en;
          rsel = RSEL_RBR;
        end
      end
      3'd1: begin
        if (dlab) begin
          slot_we[SLOT_DLM] = wr_en;
          rsel = RSEL_DLM;
        end else begin
          slot_we[SLOT_IER] = wr_en;
          rsel = RSEL_IER;
        end
      end
      3'd2: begin
        stb.fcr_wr = wr_en;
        rsel = RSEL_IIR;
      end
      3'd3: begin
        slot_we[SLOT_LCR] = wr_en;
        rsel = RSEL_LCR;
      end
      3'd4: begin
        slot_we[SLOT_MCR] = wr_en;
        rsel = RSEL_MCR;
      end
      3'd5: rsel = RSEL_LSR;
      3'd6: rsel = RSEL_MSR;
      default: begin
        slot_we[SLOT_SCR] = wr_en;
        rsel = RSEL_SCR;
      end
    endcase
  end
endmodule

// File: rtl/uart_hostregs_byte.sv
module uart_hostregs_byte #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & MASK;
  end
endmodule

// File: rtl/uart_hostregs_fcr.sv
module uart_hostregs_fcr
  import uart_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              en_bit,
  input  logic              rxflush_bit,
  input  logic              txflush_bit,
  input  logic              dma_bit,
  input  logic [1:0]        trig_code,
  output logic              fifo_en,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              dma_mode,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              en_toggle
);
  logic       en_q, dma_q, rxc_q, txc_q;
  logic [1:0] trig_q;
  logic       programmable;

  assign en_toggle    = wr && (en_bit != en_q);
  assign programmable = wr && en_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= 2'b00;
      rxc_q  <= 1'b0;
      txc_q  <= 1'b0;
    end else begin
      rxc_q <= en_toggle || (programmable && rxflush_bit);
      txc_q <= en_toggle || (programmable && txflush_bit);
      if (wr) en_q <= en_bit;
      if (programmable) begin
        dma_q  <= dma_bit;
        trig_q <= trig_code;
      end
    end
  end

  assign fifo_en  = en_q;
  assign rx_clr   = rxc_q;
  assign tx_clr   = txc_q;
  assign dma_mode = en_q && dma_q;
  assign rx_trig  = trig_count(trig_q);
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uart_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rx_data_in,
  input  logic [IID_W-1:0]  iid_in,
  input  logic [DATA_W-1:0] lsr_in,
  input  logic [DATA_W-1:0] msr_in,
  output logic              tx_wr_pulse,
  output logic [DATA_W-1:0] tx_data_out,
  output logic              rx_rd_pulse,
  output logic [3:0]        ier_out,
  output logic [DATA_W-1:0] lcr_out,
  output logic [5:0]        mcr_out,
  output logic [2*DATA_W-1:0] divisor_out,
  output logic              fifo_en,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              dma_mode,
  output logic [TRIG_W-1:0] rx_trig
);
  logic [DATA_W-1:0] slot_q [NREG];
  logic [NREG-1:0]   slot_we;
  strobes_t          stb;
  rsel_e             rsel;
  logic              dlab;
  logic              fcr_wr;
  logic              en_toggle;

  assign dlab = slot_q[SLOT_LCR][DLAB_BIT];

  uart_hostregs_decode u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .dlab    (dlab),
    .stb     (stb),
    .slot_we (slot_we),
    .rsel    (rsel)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    uart_hostregs_byte #(.W(DATA_W), .MASK(slot_mask(g))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (slot_we[g]),
      .d     (wdata),
      .q     (slot_q[g])
    );
  end

  assign fcr_wr = stb.fcr_wr;

  uart_hostregs_fcr u_fcr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (fcr_wr),
    .en_bit      (wdata[0]),
    .rxflush_bit (wdata[1]),
    .txflush_bit (wdata[2]),
    .dma_bit     (wdata[3]),
    .trig_code   (wdata[7:6]),
    .fifo_en     (fifo_en),
    .rx_clr      (rx_clr),
    .tx_clr      (tx_clr),
    .dma_mode    (dma_mode),
    .rx_trig     (rx_trig),
    .en_toggle   (en_toggle)
  );

  always_comb begin
    case (rsel)
      RSEL_RBR: rdata = rx_data_in;
      RSEL_DLL: rdata = slot_q[SLOT_DLL];
      RSEL_DLM: rdata = slot_q[SLOT_DLM];
      RSEL_IER: rdata = slot_q[SLOT_IER];
      RSEL_IIR: rdata = iir_byte(fifo_en, iid_in);
      RSEL_LCR: rdata = slot_q[SLOT_LCR];
      RSEL_MCR: rdata = slot_q[SLOT_MCR];
      RSEL_LSR: rdata = lsr_in;
      RSEL_MSR: rdata = msr_in;
      default:  rdata = slot_q[SLOT_SCR];
    endcase
  end

  assign tx_wr_pulse = stb.thr_wr;
  assign tx_data_out = wdata;
  assign rx_rd_pulse = stb.rbr_rd;
  assign ier_out     = slot_q[SLOT_IER][3:0];
  assign lcr_out     = slot_q[SLOT_LCR];
  assign mcr_out     = slot_q[SLOT_MCR][5:0];
  assign divisor_out = {slot_q[SLOT_DLM], slot_q[SLOT_DLL]};
endmodule

// File: rtl/uart_hostregs_chk.sv
module uart_hostregs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        tx_wr_pulse,
  input logic [7:0]  lcr_out,
  input logic [15:0] divisor_out,
  input logic        fifo_en,
  input logic        rx_clr,
  input logic        tx_clr,
  input logic [3:0]  rx_trig,
  input logic        fcr_wr,
  input logic        en_toggle
);
  a_r8_toggle_flushes_both: assert property (@(posedge clk) disable iff (!rst_n)
    en_toggle |=> rx_clr && tx_clr);

  a_r6_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr |=> fifo_en == $past(wdata[0]));

  a_r9_rx_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> $past(fcr_wr));

  a_r9_tx_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |-> $past(fcr_wr));

  a_r7_gated_trigger_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && !wdata[0]) |=> $stable(rx_trig));

  a_r2_dlab_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && lcr_out[7]) |-> !tx_wr_pulse);

  a_r3_divisor_only_by_dlab: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && lcr_out[7] && addr[2:1] == 2'b00) |=> $stable(divisor_out));

  a_r4_iir_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd2) |-> rdata[7:6] == {fifo_en, fifo_en});
endmodule

bind uart_hostregs uart_hostregs_chk u_chk (.*);

// File: tb/uart_hostregs_test.sv
module uart_hostregs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [7:0]  rx_data_in = '0, lsr_in = '0, msr_in = '0;
  logic [3:0]  iid_in = 4'h1;
  logic        tx_wr_pulse, rx_rd_pulse;
  logic [7:0]  tx_data_out, lcr_out;
  logic [3:0]  ier_out, rx_trig;
  logic [5:0]  mcr_out;
  logic [15:0] divisor_out;
  logic        fifo_en, rx_clr, tx_clr, dma_mode;

  always #10 clk = ~clk;

  uart_hostregs uut (.*);

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];
  int n_cmp = 0, n_mis = 0;
  event do_check;

  localparam int O_RDATA = 0, O_TXP = 1, O_RXP = 2, O_EN = 3, O_RXC = 4,
                 O_TXC = 5, O_DMA = 6, O_TRIG = 7, O_DIV = 8, O_LCR = 9,
                 O_TXD = 10, O_MCR = 11, O_IER = 12;

  function automatic logic [15:0] obs(input int sel);
    case (sel)
      O_RDATA: obs = {8'h0, rdata};
      O_TXP:   obs = {15'h0, tx_wr_pulse};
      O_RXP:   obs = {15'h0, rx_rd_pulse};
      O_EN:    obs = {15'h0, fifo_en};
      O_RXC:   obs = {15'h0, rx_clr};
      O_TXC:   obs = {15'h0, tx_clr};
      O_DMA:   obs = {15'h0, dma_mode};
      O_TRIG:  obs = {12'h0, rx_trig};
      O_DIV:   obs = divisor_out;
      O_LCR:   obs = {8'h0, lcr_out};
      O_TXD:   obs = {8'h0, tx_data_out};
      O_MCR:   obs = {10'h0, mcr_out};
      default: obs = {12'h0, ier_out};
    endcase
  endfunction

  // monitor: pops expected items and compares with the live outputs
  always @(do_check) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb.pop_front();
      act = obs(it.sel);
      n_cmp++;
      if (act !== it.exp) begin
        n_mis++;
        $display("FAIL %s (output %0d): actual %h expected %h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_out(input int sel, input logic [15:0] v, input string req);
    item_t it;
    it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic check();
    -> do_check;
    wait (sb.size() == 0);
    #0;
  endtask

  task automatic put(input logic [2:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = r;
    #4;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    put(a, d, 1'b1, 1'b0);
    tick();
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] v, input string req);
    put(a, 8'h00, 1'b0, 1'b1);
    expect_out(O_RDATA, {8'h0, v}, req);
    check();
    tick();
  endtask

  // control write, then the pulse edge, then the edge after it
  task automatic fcr_write(input logic [7:0] d, input logic rxp, input logic txp,
                           input string req);
    wr(3'd2, d);
    settle();
    expect_out(O_RXC, {15'h0, rxp}, req);
    expect_out(O_TXC, {15'h0, txp}, req);
    check();
    settle();
    expect_out(O_RXC, 16'h0, "R9 rx pulse single cycle");
    expect_out(O_TXC, 16'h0, "R9 tx pulse single cycle");
    check();
  endtask

  bit done = 1'b0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    expect_out(O_EN, 16'h0, "R1 fifo_en");
    expect_out(O_DMA, 16'h0, "R1 dma_mode");
    expect_out(O_RXC, 16'h0, "R1 rx_clr");
    expect_out(O_TXC, 16'h0, "R1 tx_clr");
    expect_out(O_TRIG, 16'd1, "R1 rx_trig");
    expect_out(O_DIV, 16'h0, "R1 divisor");
    expect_out(O_LCR, 16'h0, "R1 lcr");
    check();
    rd_expect(3'd7, 8'h00, "R1 scratch");
    rd_expect(3'd1, 8'h00, "R1 ier");
    rd_expect(3'd4, 8'h00, "R1 mcr");

    // R2 data path at address 0
    put(3'd0, 8'h5A, 1'b1, 1'b0);
    expect_out(O_TXP, 16'h1, "R2 push strobe");
    expect_out(O_TXD, 16'h5A, "R2 push data");
    expect_out(O_RXP, 16'h0, "R2 no pop on write");
    check();
    tick();
    rx_data_in = 8'hC3;
    put(3'd0, 8'h00, 1'b0, 1'b1);
    expect_out(O_RDATA, 16'hC3, "R2 receive byte");
    expect_out(O_RXP, 16'h1, "R2 pop strobe");
    check();
    tick();

    // R2/R3 divisor access
    wr(3'd3, 8'h83);
    settle();
    expect_out(O_LCR, 16'h83, "R5 lcr write");
    check();
    put(3'd0, 8'h34, 1'b1, 1'b0);
    expect_out(O_TXP, 16'h0, "R2 no push with dlab");
    check();
    tick();
    wr(3'd1, 8'h12);
    settle();
    expect_out(O_DIV, 16'h1234, "R3 divisor value");
    check();
    put(3'd0, 8'h00, 1'b0, 1'b1);
    expect_out(O_RDATA, 16'h34, "R2 divisor low read");
    expect_out(O_RXP, 16'h0, "R2 no pop with dlab");
    check();
    tick();
    rd_expect(3'd1, 8'h12, "R3 divisor high read");
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    settle();
    expect_out(O_IER, 16'h0F, "R3 ier stored bits");
    expect_out(O_DIV, 16'h1234, "R3 divisor kept");
    check();
    rd_expect(3'd1, 8'h0F, "R3 ier read");
    rd_expect(3'd3, 8'h03, "R5 lcr read");

    // R5 remaining addresses
    wr(3'd7, 8'hA5);
    wr(3'd4, 8'hFF);
    rd_expect(3'd7, 8'hA5, "R5 scratch");
    rd_expect(3'd4, 8'h3F, "R5 mcr masked");
    lsr_in = 8'h60; msr_in = 8'hB0;
    rd_expect(3'd5, 8'h60, "R5 line status");
    rd_expect(3'd6, 8'hB0, "R5 modem status");
    wr(3'd5, 8'h11);
    wr(3'd6, 8'h22);
    rd_expect(3'd7, 8'hA5, "R5 scratch after status writes");
    rd_expect(3'd4, 8'h3F, "R5 mcr after status writes");
    rd_expect(3'd3, 8'h03, "R5 lcr after status writes");
    settle();
    expect_out(O_DIV, 16'h1234, "R5 divisor after status writes");
    check();

    // R4 identification read with queues off
    iid_in = 4'hC;
    rd_expect(3'd2, 8'h0C, "R4 iir disabled");

    // R6 R8 R11: enable with top trigger code, no explicit flush
    fcr_write(8'hC1, 1'b1, 1'b1, "R8 enable change flushes");
    expect_out(O_EN, 16'h1, "R6 enabled");
    expect_out(O_TRIG, 16'd14, "R11 code 11");
    expect_out(O_DMA, 16'h0, "R10 dma off");
    check();
    rd_expect(3'd2, 8'hCC, "R4 iir enabled");

    // R9 individual flushes with enable held
    fcr_write(8'h03, 1'b1, 1'b0, "R9 rx flush only");
    expect_out(O_TRIG, 16'd1, "R11 code 00");
    check();
    fcr_write(8'h05, 1'b0, 1'b1, "R9 tx flush only");
    fcr_write(8'h01, 1'b0, 1'b0, "R9 no flush");
    fcr_write(8'h49, 1'b0, 1'b0, "R9 no flush dma write");
    expect_out(O_DMA, 16'h1, "R10 dma on");
    expect_out(O_TRIG, 16'd4, "R11 code 01");
    check();
    fcr_write(8'h8F, 1'b1, 1'b1, "R9 both flush bits");
    expect_out(O_TRIG, 16'd8, "R11 code 10");
    expect_out(O_DMA, 16'h1, "R10 dma kept on");
    check();

    // R7 R8 R10 disabling write carrying other bits
    fcr_write(8'h46, 1'b1, 1'b1, "R8 disable flushes both");
    expect_out(O_EN, 16'h0, "R6 disabled");
    expect_out(O_TRIG, 16'd8, "R7 trigger kept");
    expect_out(O_DMA, 16'h0, "R10 dma forced off");
    check();
    fcr_write(8'hC6, 1'b0, 1'b0, "R7 gated flush bits");
    expect_out(O_TRIG, 16'd8, "R7 trigger still kept");
    expect_out(O_EN, 16'h0, "R7 still disabled");
    check();
    rd_expect(3'd2, 8'h0C, "R4 no control readback");

    // R8 enable again together with rx flush: one pulse each
    fcr_write(8'h03, 1'b1, 1'b1, "R8 enable with rx flush");
    expect_out(O_EN, 16'h1, "R6 enabled again");
    expect_out(O_DMA, 16'h0, "R10 dma reprogrammed off");
    expect_out(O_TRIG, 16'd1, "R11 code 00 again");
    check();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule